// File: doc/BRIEF.md
# Instruction cycle accounting counter

This block keeps performance statistics for an in-order processor core whose branches may carry a delay slot. Each time the core retires an instruction it presents a retire strobe with a class code and a few flags: whether a branch was taken, whether that taken branch uses a delay slot, whether the retiring instruction itself sits in a delay slot, and whether it is the halt instruction. The block adds one to a running instruction count. It also adds the estimated cost of that instruction to a running cycle count. The cost is one base cycle plus a fixed penalty that depends on the class.

A branch or return that retires while marked as sitting in a delay slot is not a legal program. The block raises a one-cycle flag for it and leaves the counters untouched. Breakpoints never change the counters. A reported cycle value is presented alongside the raw cycle count. It is the count plus two, or zero while the count is zero. A synchronous clear zeroes both counters. All outputs are registered and change one clock after the retire that causes them. Counters are 32 bits by default and wrap silently.

Top module: `instr_cost_counter`

## Requirements
- R1: A counted retire adds exactly one to `inst_count`. An ALU-class retire (class code 0) that is not a halt adds exactly one to `cycle_count`.
- R2: A memory-access retire (class code 1, loads and stores) adds two cycles.
- R3: Multiply (class code 2), barrel-shift (class code 3) and custom-extension (class code 4) retires each add two cycles.
- R4: A divide retire (class code 5) adds 34 cycles (one base cycle plus 33).
- R5: A branch or return (class code 6) adds one cycle when not taken. It adds two cycles when taken with `br_has_slot`=1, and three cycles when taken with `br_has_slot`=0.
- R6: An instruction retiring with `in_slot`=1 and a class other than 6 or 7 is counted as its own instruction, with the cost of its own class.
- R7: A retire with class 6, `in_slot`=1 and `is_halt`=0 sets `illegal_slot` high in the next cycle and leaves both counters unchanged. In every other cycle `illegal_slot` is low.
- R8: A breakpoint retire (class code 7, `is_halt`=0) leaves both counters unchanged, whether or not `in_slot` is set.
- R9: A retire with `is_halt`=1 adds one instruction and two cycles, whatever the class and slot inputs are.
- R10: `cycle_report` equals `cycle_count`+2 when `cycle_count` is nonzero, and 0 when it is zero.
- R11: `clr`=1 zeroes both counters in the next cycle, even when a retire is presented in the same cycle.
- R12: After reset, and in any cycle without a retire or a clear, both counters hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous counter clear, takes priority over a retire |
| retire_vld | input | 1 | One instruction retires this cycle |
| retire_cls | input | 3 | Class code: 0 ALU, 1 memory, 2 multiply, 3 shift, 4 custom, 5 divide, 6 branch/return, 7 breakpoint |
| br_taken | input | 1 | The retiring branch was taken |
| br_has_slot | input | 1 | The taken branch executes a delay-slot instruction |
| in_slot | input | 1 | The retiring instruction occupies a delay slot |
| is_halt | input | 1 | The retiring instruction is the halt instruction |
| inst_count | output | 32 | Running retired-instruction count |
| cycle_count | output | 32 | Running estimated cycle count |
| cycle_report | output | 32 | cycle_count+2 when nonzero, else 0 |
| illegal_slot | output | 1 | Pulses high one cycle after a branch retires in a delay slot |

## Verification
The clear and a retire can fall in the same cycle. The clear must win, so both counters read zero, and the reported value must also drop to zero, not to the cost of the retire. The bench provokes this by driving `clr` together with a divide retire on counters that are already nonzero. It also drives `clr` together with an illegal delay-slot branch. A behavioural model judges the counters, the reported value and the illegal flag one clock later, and it does so on every clock of the run.

// File: rtl/icc_pkg.sv
package icc_pkg;

  typedef enum logic [2:0] {
    CLS_ALU    = 3'd0,
    CLS_MEM    = 3'd1,
    CLS_MUL    = 3'd2,
    CLS_SHIFT  = 3'd3,
    CLS_CUSTOM = 3'd4,
    CLS_DIV    = 3'd5,
    CLS_BRANCH = 3'd6,
    CLS_BREAK  = 3'd7
  } icc_cls_e;

endpackage

// File: rtl/icc_cost.sv
module icc_cost #(
  parameter int CW        = 6,
  parameter int DIV_EXTRA = 33
) (
  input  logic          vld,
  input  logic [2:0]    cls,
  input  logic          taken,
  input  logic          has_slot,
  input  logic          in_slot,
  input  logic          halt,
  output logic          counted,
  output logic          illegal,
  output logic [CW-1:0] cost
);
  import icc_pkg::*;

  icc_cls_e     c;
  logic [CW-1:0] extra;

  assign c = icc_cls_e'(cls);

  always_comb begin
    case (c)
      CLS_MEM, CLS_MUL, CLS_SHIFT, CLS_CUSTOM: extra = CW'(1);
      CLS_DIV:    extra = CW'(DIV_EXTRA);
      CLS_BRANCH: extra = taken ? (has_slot ? CW'(1) : CW'(2)) : CW'(0);
      default:    extra = CW'(0);
    endcase
  end

  always_comb begin
    illegal = vld && !halt && in_slot && (c == CLS_BRANCH);
    counted = vld && !illegal && (halt || (c != CLS_BREAK));
    cost    = halt ? CW'(2) : (CW'(1) + extra);
  end

endmodule

// File: rtl/icc_accum.sv
module icc_accum #(
  parameter int W  = 32,
  parameter int CW = 6,
  parameter int OFS = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          en,
  input  logic [CW-1:0] cost,
  output logic [W-1:0]  insts,
  output logic [W-1:0]  cycles,
  output logic [W-1:0]  report
);

  logic [W-1:0] insts_nxt;
  logic [W-1:0] cycles_nxt;

  always_comb begin
    insts_nxt  = insts;
    cycles_nxt = cycles;
    if (clr) begin
      insts_nxt  = '0;
      cycles_nxt = '0;
    end else if (en) begin
      insts_nxt  = insts + W'(1);
      cycles_nxt = cycles + {{(W-CW){1'b0}}, cost};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      insts  <= '0;
      cycles <= '0;
      report <= '0;
    end else begin
      insts  <= insts_nxt;
      cycles <= cycles_nxt;
      report <= (cycles_nxt == '0) ? '0 : cycles_nxt + W'(OFS);
    end
  end

endmodule

// File: rtl/instr_cost_counter.sv
module instr_cost_counter #(
  parameter int W         = 32,
  parameter int DIV_EXTRA = 33,
  parameter int REPORT_OFS = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         retire_vld,
  input  logic [2:0]   retire_cls,
  input  logic         br_taken,
  input  logic         br_has_slot,
  input  logic         in_slot,
  input  logic         is_halt,
  output logic [W-1:0] inst_count,
  output logic [W-1:0] cycle_count,
  output logic [W-1:0] cycle_report,
  output logic         illegal_slot
);

  localparam int CW = $clog2(DIV_EXTRA + 4);

  logic          counted;
  logic          illegal;
  logic [CW-1:0] cost;

  icc_cost #(.CW(CW), .DIV_EXTRA(DIV_EXTRA)) u_cost (
    .vld      (retire_vld),
    .cls      (retire_cls),
    .taken    (br_taken),
    .has_slot (br_has_slot),
    .in_slot  (in_slot),
    .halt     (is_halt),
    .counted  (counted),
    .illegal  (illegal),
    .cost     (cost)
  );

  icc_accum #(.W(W), .CW(CW), .OFS(REPORT_OFS)) u_accum (
    .clk    (clk),
    .rst    (rst),
    .clr    (clr),
    .en     (counted),
    .cost   (cost),
    .insts  (inst_count),
    .cycles (cycle_count),
    .report (cycle_report)
  );

  always_ff @(posedge clk) begin
    if (rst) illegal_slot <= 1'b0;
    else     illegal_slot <= illegal && !clr;
  end

endmodule

// File: rtl/icc_checker.sv
module icc_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         clr,
  input logic         retire_vld,
  input logic [2:0]   retire_cls,
  input logic         in_slot,
  input logic         is_halt,
  input logic [W-1:0] inst_count,
  input logic [W-1:0] cycle_count,
  input logic [W-1:0] cycle_report,
  input logic         illegal_slot
);

  logic bad_branch;
  logic brk_only;
  assign bad_branch = retire_vld && !clr && !is_halt && in_slot && (retire_cls == 3'd6);
  assign brk_only   = retire_vld && !clr && !is_halt && (retire_cls == 3'd7);

  a_r11_clear_zeroes: assert property (@(posedge clk) disable iff (rst)
    clr |=> (inst_count == '0) && (cycle_count == '0));

  a_r10_report_offset: assert property (@(posedge clk) disable iff (rst)
    cycle_report == ((cycle_count == '0) ? '0 : cycle_count + W'(2)));

  a_r7_illegal_no_count: assert property (@(posedge clk) disable iff (rst)
    bad_branch |=> illegal_slot && $stable(inst_count) && $stable(cycle_count));

  a_r7_illegal_only_then: assert property (@(posedge clk) disable iff (rst)
    !bad_branch |=> !illegal_slot);

  a_r8_break_ignored: assert property (@(posedge clk) disable iff (rst)
    brk_only |=> $stable(inst_count) && $stable(cycle_count));

  a_r12_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!retire_vld && !clr) |=> $stable(inst_count) && $stable(cycle_count));

  a_r9_halt_cost: assert property (@(posedge clk) disable iff (rst)
    (retire_vld && is_halt && !clr) |=>
      (inst_count == $past(inst_count) + W'(1)) && (cycle_count == $past(cycle_count) + W'(2)));

endmodule

bind instr_cost_counter icc_checker #(.W(W)) u_icc_checker (
  .clk          (clk),
  .rst          (rst),
  .clr          (clr),
  .retire_vld   (retire_vld),
  .retire_cls   (retire_cls),
  .in_slot      (in_slot),
  .is_halt      (is_halt),
  .inst_count   (inst_count),
  .cycle_count  (cycle_count),
  .cycle_report (cycle_report),
  .illegal_slot (illegal_slot)
);

// File: tb/test_instr_cost_counter.sv
`timescale 1ns/1ps
module test_instr_cost_counter;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clr = 1'b0;
  logic        retire_vld = 1'b0;
  logic [2:0]  retire_cls = 3'd0;
  logic        br_taken = 1'b0;
  logic        br_has_slot = 1'b0;
  logic        in_slot = 1'b0;
  logic        is_halt = 1'b0;
  logic [31:0] inst_count;
  logic [31:0] cycle_count;
  logic [31:0] cycle_report;
  logic        illegal_slot;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] m_inst = 0;
  logic [31:0] m_cyc = 0;
  logic        m_ill = 0;

  always #10 clk = ~clk;

  instr_cost_counter i_instr_cost_counter (
    .clk(clk), .rst(rst), .clr(clr), .retire_vld(retire_vld),
    .retire_cls(retire_cls), .br_taken(br_taken), .br_has_slot(br_has_slot),
    .in_slot(in_slot), .is_halt(is_halt), .inst_count(inst_count),
    .cycle_count(cycle_count), .cycle_report(cycle_report),
    .illegal_slot(illegal_slot)
  );

  function automatic int unsigned cost_of(logic [2:0] c, logic tk, logic hs, logic h);
    if (h) return 2;
    case (c)
      3'd1, 3'd2, 3'd3, 3'd4: return 2;
      3'd5: return 34;
      3'd6: return tk ? (hs ? 2 : 3) : 1;
      default: return 1;
    endcase
  endfunction

  task automatic compare(string tag);
    logic [31:0] rep;
    rep = (m_cyc == 0) ? 32'd0 : m_cyc + 32'd2;
    checks += 4;
    if (inst_count !== m_inst) begin
      errors++; $display("FAIL %s inst_count actual=%0d expected=%0d", tag, inst_count, m_inst);
    end
    if (cycle_count !== m_cyc) begin
      errors++; $display("FAIL %s cycle_count actual=%0d expected=%0d", tag, cycle_count, m_cyc);
    end
    if (cycle_report !== rep) begin
      errors++; $display("FAIL %s/R10 cycle_report actual=%0d expected=%0d", tag, cycle_report, rep);
    end
    if (illegal_slot !== m_ill) begin
      errors++; $display("FAIL %s/R7 illegal_slot actual=%0b expected=%0b", tag, illegal_slot, m_ill);
    end
  endtask

  // Drive one cycle at a falling edge, update the model, compare at the next falling edge.
  task automatic step(logic v, logic [2:0] c, logic tk, logic hs, logic ins,
                      logic h, logic cl, string tag);
    logic bad;
    retire_vld = v; retire_cls = c; br_taken = tk; br_has_slot = hs;
    in_slot = ins; is_halt = h; clr = cl;
    bad = v && !h && ins && (c == 3'd6);
    if (cl) begin
      m_inst = 0; m_cyc = 0;
    end else if (v && !bad && (h || c != 3'd7)) begin
      m_inst = m_inst + 1;
      m_cyc  = m_cyc + cost_of(c, tk, hs, h);
    end
    m_ill = bad && !cl;
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    compare("R12 reset");
    rst = 1'b0;
    step(0, 0, 0, 0, 0, 0, 0, "R12 idle after reset");
    step(1, 3'd0, 0, 0, 0, 0, 0, "R1 alu");
    step(1, 3'd0, 1, 1, 0, 0, 0, "R1 alu flags ignored");
    step(1, 3'd1, 0, 0, 0, 0, 0, "R2 memory");
    step(1, 3'd2, 0, 0, 0, 0, 0, "R3 multiply");
    step(1, 3'd3, 0, 0, 0, 0, 0, "R3 shift");
    step(1, 3'd4, 0, 0, 0, 0, 0, "R3 custom");
    step(1, 3'd5, 0, 0, 0, 0, 0, "R4 divide");
    step(1, 3'd6, 0, 0, 0, 0, 0, "R5 branch not taken");
    step(1, 3'd6, 1, 1, 0, 0, 0, "R5 taken with slot");
    step(1, 3'd5, 0, 0, 1, 0, 0, "R6 divide in slot");
    step(1, 3'd6, 1, 0, 0, 0, 0, "R5 taken without slot");
    step(1, 3'd6, 1, 1, 0, 0, 0, "R5 taken with slot 2");
    step(1, 3'd6, 1, 1, 1, 0, 0, "R7 branch in slot");
    step(1, 3'd1, 0, 0, 1, 0, 0, "R6 memory in slot");
    step(1, 3'd7, 0, 0, 0, 0, 0, "R8 breakpoint");
    step(1, 3'd7, 0, 0, 1, 0, 0, "R8 breakpoint in slot");
    step(0, 3'd5, 1, 1, 1, 1, 0, "R12 no strobe");
    step(1, 3'd0, 0, 0, 0, 1, 0, "R9 halt");
    step(1, 3'd5, 0, 0, 0, 1, 0, "R9 halt divide class");
    step(1, 3'd6, 1, 1, 1, 1, 0, "R9 halt branch in slot");
    step(0, 0, 0, 0, 0, 0, 0, "R12 hold");
    step(1, 3'd5, 0, 0, 0, 0, 1, "R11 clear with divide");
    step(1, 3'd0, 0, 0, 0, 0, 0, "R10 small count");
    step(1, 3'd6, 1, 1, 1, 0, 1, "R11 clear with illegal");
    step(0, 0, 0, 0, 0, 0, 1, "R11 clear idle");
    for (int i = 0; i < 40; i++)
      step(1, 3'(i % 8), i[0], i[1], i[2], (i % 13) == 0, (i % 17) == 16, "R6 mixed");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule